// File: doc/BRIEF.md
# Processor Status and Exception Context Registers

This block keeps the machine status word and the program counter of a small 16-bit processor, together with the state saved when the processor takes an exception. Three exception classes are supported: a normal interrupt, a fast interrupt and a software interrupt. Each of the two hardware interrupt classes owns a saved status word and a saved return address, held as a 6-bit upper part and a 16-bit lower part. The software interrupt owns only a saved status word. Its return address leaves the block through a side port and is written into a general-purpose register pair, with the upper 6 bits going to the extension half and the lower 16 bits to the base half.

The surrounding sequencer reads and writes the registers through one select-addressed port. It loads the program counter, feeds flag results from the ALU and from the zero detectors of index registers 6 and 7, and raises one entry strobe per exception class, plus a return strobe with a 2-bit class selector. In user mode the mode bit, the trace bit and both interrupt enables are protected against register writes. The only way back into privileged mode is exception entry.

Top module: `sreg_ctx`

## Requirements
- R1: After reset the status word reads 0x0040, so privileged mode is on and all other bits are 0. The program counter and every save register read 0.
- R2: Status layout: bit0 fast-interrupt enable, bit1 interrupt enable, bit2 trace enable, bit3 overflow, bit4 zero flag of index register 6, bit5 zero flag of index register 7, bit6 privileged mode, bit15 true flag. Bits 14..7 read 0 in the status word and in every saved status word. Bit 0 of the program counter and of each saved low return-address half reads 0.
- R3: In privileged mode, a status write (select 0) loads every defined status bit from the write data.
- R4: In user mode, a status write leaves bits 6, 2, 1 and 0 unchanged and loads bits 15, 5, 4 and 3.
- R5: The overflow, true and two zero-flag strobes update their bits in either mode. A strobe wins over a status write to the same bit in the same cycle.
- R6: Normal-interrupt entry saves the current status word and the return address (the current program counter: upper 6 bits and lower 16 bits) into the normal-interrupt set. It then sets bit 6 and clears bit 1.
- R7: Fast-interrupt entry saves into its own set and leaves the normal-interrupt set untouched. It sets bit 6 and clears bits 0 and 1.
- R8: Software-interrupt entry saves the status word into its own save register and sets bit 6. In the same cycle it asserts the register-pair write strobe, with the upper 6 and lower 16 program-counter bits on the extension and base outputs.
- R9: An entry strobe takes precedence over flag strobes, status writes and a return strobe in the same cycle. The status word follows from the pre-entry value only, and the program counter is not restored.
- R10: A return strobe restores the status word and the program counter from the set chosen by the class input: 0 normal interrupt, 1 fast interrupt, 2 software interrupt. For class 2 the counter comes from the return-address input, with bit 0 cleared.
- R11: Register select map for read and write: 0 status, 1 counter low, 2 counter high, 3/4/5 normal-interrupt low/high/status, 6/7/8 fast-interrupt low/high/status, 9 software-interrupt status, 10..15 read 0. High halves occupy data bits 5..0.
- R12: Register updates appear one cycle after the strobe. Reads and the register-pair side port are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 4 | Write register select |
| wr_data | input | 16 | Write data |
| rd_sel | input | 4 | Read register select |
| rd_data | output | 16 | Read data |
| pc_ld | input | 1 | Program counter load strobe |
| pc_in | input | 22 | Program counter load value |
| v_we | input | 1 | Overflow flag update strobe |
| v_val | input | 1 | New overflow value |
| t_we | input | 1 | True flag update strobe |
| t_val | input | 1 | New true flag value |
| z_we | input | 2 | Zero-flag strobes, bit0 index reg 6, bit1 index reg 7 |
| z_val | input | 2 | Zero-flag values, same order |
| exc_irq | input | 1 | Normal-interrupt entry strobe |
| exc_fiq | input | 1 | Fast-interrupt entry strobe |
| exc_swi | input | 1 | Software-interrupt entry strobe |
| ret_en | input | 1 | Exception return strobe |
| ret_cls | input | 2 | Return class select |
| swi_ret_addr | input | 22 | Return address read back from the register pair |
| gpr_we | output | 1 | Register pair write strobe |
| gpr_ext | output | 6 | Upper return-address bits for the extension register |
| gpr_base | output | 16 | Lower return-address bits for the base register |
| sr | output | 16 | Current status word |
| pc | output | 22 | Current program counter |

## Verification
Every stored result (status word, counter, save registers) is due on the first clock edge after its strobe. The bench drives stimulus one time unit after a rising edge, steps a single edge and compares one time unit later, so each comparison sees exactly one update. The read port and the register-pair side port have no register in their path. They are compared in the same cycle as their select or strobe, before the edge that stores the entry. After reset is released, two further edges pass before the first stimulus, because the internal reset release is synchronised.

// File: rtl/sctx_pkg.sv
package sctx_pkg;
  localparam int SR_W  = 16;
  localparam int PC_W  = 22;
  localparam int PCL_W = 16;
  localparam int PCH_W = PC_W - PCL_W;
  localparam int SEL_W = 4;

  localparam int B_FE = 0;
  localparam int B_IE = 1;
  localparam int B_TE = 2;
  localparam int B_V  = 3;
  localparam int B_Z6 = 4;
  localparam int B_Z7 = 5;
  localparam int B_PM = 6;
  localparam int B_T  = 15;

  localparam logic [SR_W-1:0] SR_IMPL = 16'h807F;
  localparam logic [SR_W-1:0] SR_PROT = 16'h0047;
  localparam logic [SR_W-1:0] SR_RST  = 16'h0040;

  typedef enum logic [1:0] {
    CLS_IRQ = 2'd0,
    CLS_FIQ = 2'd1,
    CLS_SWI = 2'd2
  } cls_e;

  typedef enum logic [SEL_W-1:0] {
    SEL_SR      = 4'd0,
    SEL_PCL     = 4'd1,
    SEL_PCH     = 4'd2,
    SEL_IRQ_PCL = 4'd3,
    SEL_IRQ_PCH = 4'd4,
    SEL_IRQ_SSR = 4'd5,
    SEL_FIQ_PCL = 4'd6,
    SEL_FIQ_PCH = 4'd7,
    SEL_FIQ_SSR = 4'd8,
    SEL_SWI_SSR = 4'd9
  } sel_e;
endpackage

// File: rtl/sctx_rst_sync.sv
module sctx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rst_q_n = chain[STAGES-1];
endmodule

// File: rtl/sctx_status.sv
module sctx_status
  import sctx_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [SR_W-1:0] wr_data,
  input  logic            v_we,
  input  logic            v_val,
  input  logic            t_we,
  input  logic            t_val,
  input  logic [1:0]      z_we,
  input  logic [1:0]      z_val,
  input  logic            ent_irq,
  input  logic            ent_fiq,
  input  logic            ent_swi,
  input  logic            ret,
  input  logic [SR_W-1:0] ret_sr,
  output logic [SR_W-1:0] sr
);
  logic [SR_W-1:0] sr_q, sr_d, wmask;
  logic            sr_en, ent_any;

  assign ent_any = ent_irq | ent_fiq | ent_swi;
  assign sr_en   = wr | v_we | t_we | (|z_we) | ret | ent_any;
  assign wmask   = sr_q[B_PM] ? SR_IMPL : (SR_IMPL & ~SR_PROT);

  always_comb begin
    sr_d = sr_q;
    if (wr) sr_d = (sr_q & ~wmask) | (wr_data & wmask);
    if (v_we)    sr_d[B_V]  = v_val;
    if (t_we)    sr_d[B_T]  = t_val;
    if (z_we[0]) sr_d[B_Z6] = z_val[0];
    if (z_we[1]) sr_d[B_Z7] = z_val[1];
    if (ret) sr_d = ret_sr & SR_IMPL;
    if (ent_any) begin
      sr_d = sr_q;
      sr_d[B_PM] = 1'b1;
      if (ent_irq | ent_fiq) sr_d[B_IE] = 1'b0;
      if (ent_fiq)           sr_d[B_FE] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr_q <= SR_RST;
    else if (sr_en) sr_q <= sr_d;
  end

  assign sr = sr_q;
endmodule

// File: rtl/sctx_saveset.sv
module sctx_saveset
  import sctx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap,
  input  logic [PC_W-1:0]  cap_pc,
  input  logic [SR_W-1:0]  cap_sr,
  input  logic             wr_pcl,
  input  logic             wr_pch,
  input  logic             wr_ssr,
  input  logic [SR_W-1:0]  wr_data,
  output logic [PC_W-1:0]  sv_pc,
  output logic [SR_W-1:0]  sv_sr
);
  logic [PC_W-1:0] pc_q, pc_d;
  logic [SR_W-1:0] ssr_q, ssr_d;
  logic            pc_en, ssr_en;

  assign pc_en  = cap | wr_pcl | wr_pch;
  assign ssr_en = cap | wr_ssr;

  always_comb begin
    pc_d  = pc_q;
    ssr_d = ssr_q;
    if (wr_pcl) pc_d[PCL_W-1:0]    = wr_data;
    if (wr_pch) pc_d[PC_W-1:PCL_W] = wr_data[PCH_W-1:0];
    if (wr_ssr) ssr_d = wr_data;
    if (cap) begin
      pc_d  = cap_pc;
      ssr_d = cap_sr;
    end
    pc_d[0] = 1'b0;
    ssr_d   = ssr_d & SR_IMPL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      ssr_q <= '0;
    end else begin
      if (pc_en)  pc_q  <= pc_d;
      if (ssr_en) ssr_q <= ssr_d;
    end
  end

  assign sv_pc = pc_q;
  assign sv_sr = ssr_q;
endmodule

// File: rtl/sreg_ctx.sv
module sreg_ctx
  import sctx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [SR_W-1:0]   wr_data,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [SR_W-1:0]   rd_data,
  input  logic              pc_ld,
  input  logic [PC_W-1:0]   pc_in,
  input  logic              v_we,
  input  logic              v_val,
  input  logic              t_we,
  input  logic              t_val,
  input  logic [1:0]        z_we,
  input  logic [1:0]        z_val,
  input  logic              exc_irq,
  input  logic              exc_fiq,
  input  logic              exc_swi,
  input  logic              ret_en,
  input  logic [1:0]        ret_cls,
  input  logic [PC_W-1:0]   swi_ret_addr,
  output logic              gpr_we,
  output logic [PCH_W-1:0]  gpr_ext,
  output logic [PCL_W-1:0]  gpr_base,
  output logic [SR_W-1:0]   sr,
  output logic [PC_W-1:0]   pc
);
  localparam int NSET = 2;

  logic                       rst_i_n;
  logic                       exc_any, ret_go;
  logic [NSET-1:0]            set_cap;
  logic [NSET-1:0][PC_W-1:0]  set_pc;
  logic [NSET-1:0][SR_W-1:0]  set_sr;
  logic [SR_W-1:0]            swi_ssr_q, ret_sr;
  logic [PC_W-1:0]            pc_q, pc_d, ret_pc;
  logic                       pc_en;

  sctx_rst_sync #(.STAGES(2)) u_rsync (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_i_n)
  );

  assign exc_any = exc_irq | exc_fiq | exc_swi;
  assign ret_go  = ret_en & ~exc_any;
  assign set_cap = {exc_fiq, exc_irq};

  sctx_status u_stat (
    .clk(clk), .rst_n(rst_i_n),
    .wr(wr_en && wr_sel == SEL_SR), .wr_data(wr_data),
    .v_we(v_we), .v_val(v_val), .t_we(t_we), .t_val(t_val),
    .z_we(z_we), .z_val(z_val),
    .ent_irq(exc_irq), .ent_fiq(exc_fiq), .ent_swi(exc_swi),
    .ret(ret_go), .ret_sr(ret_sr), .sr(sr)
  );

  for (genvar k = 0; k < NSET; k++) begin : g_set
    localparam logic [SEL_W-1:0] BASE = SEL_W'(int'(SEL_IRQ_PCL) + 3 * k);
    sctx_saveset u_set (
      .clk(clk), .rst_n(rst_i_n),
      .cap(set_cap[k]), .cap_pc(pc_q), .cap_sr(sr),
      .wr_pcl(wr_en && wr_sel == BASE),
      .wr_pch(wr_en && wr_sel == BASE + SEL_W'(1)),
      .wr_ssr(wr_en && wr_sel == BASE + SEL_W'(2)),
      .wr_data(wr_data),
      .sv_pc(set_pc[k]), .sv_sr(set_sr[k])
    );
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)     swi_ssr_q <= '0;
    else if (exc_swi) swi_ssr_q <= sr;
    else if (wr_en && wr_sel == SEL_SWI_SSR) swi_ssr_q <= wr_data & SR_IMPL;
  end

  always_comb begin
    case (ret_cls)
      CLS_IRQ: begin ret_pc = set_pc[0]; ret_sr = set_sr[0];  end
      CLS_FIQ: begin ret_pc = set_pc[1]; ret_sr = set_sr[1];  end
      CLS_SWI: begin ret_pc = swi_ret_addr; ret_sr = swi_ssr_q; end
      default: begin ret_pc = pc_q; ret_sr = sr; end
    endcase
  end

  assign pc_en = ret_go | pc_ld | (wr_en && (wr_sel == SEL_PCL || wr_sel == SEL_PCH));

  always_comb begin
    pc_d = pc_q;
    if (wr_en && wr_sel == SEL_PCL) pc_d[PCL_W-1:0]    = wr_data;
    if (wr_en && wr_sel == SEL_PCH) pc_d[PC_W-1:PCL_W] = wr_data[PCH_W-1:0];
    if (pc_ld)  pc_d = pc_in;
    if (ret_go) pc_d = ret_pc;
    pc_d[0] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)   pc_q <= '0;
    else if (pc_en) pc_q <= pc_d;
  end

  assign pc       = pc_q;
  assign gpr_we   = exc_swi;
  assign gpr_ext  = pc_q[PC_W-1:PCL_W];
  assign gpr_base = pc_q[PCL_W-1:0];

  always_comb begin
    case (rd_sel)
      SEL_SR:      rd_data = sr;
      SEL_PCL:     rd_data = pc_q[PCL_W-1:0];
      SEL_PCH:     rd_data = SR_W'(pc_q[PC_W-1:PCL_W]);
      SEL_IRQ_PCL: rd_data = set_pc[0][PCL_W-1:0];
      SEL_IRQ_PCH: rd_data = SR_W'(set_pc[0][PC_W-1:PCL_W]);
      SEL_IRQ_SSR: rd_data = set_sr[0];
      SEL_FIQ_PCL: rd_data = set_pc[1][PCL_W-1:0];
      SEL_FIQ_PCH: rd_data = SR_W'(set_pc[1][PC_W-1:PCL_W]);
      SEL_FIQ_SSR: rd_data = set_sr[1];
      SEL_SWI_SSR: rd_data = swi_ssr_q;
      default:     rd_data = '0;
    endcase
  end
endmodule

// File: rtl/sctx_chk.sv
module sctx_chk
  import sctx_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             exc_irq,
  input logic             exc_fiq,
  input logic             exc_swi,
  input logic             ret_en,
  input logic [1:0]       ret_cls,
  input logic [SR_W-1:0]  sr,
  input logic [PC_W-1:0]  pc,
  input logic [PC_W-1:0]  irq_pc,
  input logic [SR_W-1:0]  irq_ssr,
  input logic [PC_W-1:0]  fiq_pc,
  input logic [SR_W-1:0]  fiq_ssr,
  input logic [SR_W-1:0]  swi_ssr
);
  logic any_exc;
  assign any_exc = exc_irq | exc_fiq | exc_swi;

  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sr[14:7] == 8'h00 && pc[0] == 1'b0 && irq_pc[0] == 1'b0 && fiq_pc[0] == 1'b0);

  p_user_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sr[B_PM] && !any_exc && !ret_en) |=> (!sr[B_PM] && sr[2:0] == $past(sr[2:0])));

  p_irq_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    exc_irq |=> (irq_ssr == $past(sr) && irq_pc == $past(pc) && sr[B_PM] && !sr[B_IE]));

  p_fiq_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    exc_fiq |=> (fiq_ssr == $past(sr) && fiq_pc == $past(pc) && sr[B_PM] && !sr[B_IE] && !sr[B_FE]));

  p_swi_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    exc_swi |=> (swi_ssr == $past(sr) && sr[B_PM]));

  p_entry_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    any_exc |=> (pc == $past(pc) || $past(ret_en) == 1'b0));

  p_ret_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_en && !any_exc && ret_cls == 2'd0) |=> (sr == $past(irq_ssr) && pc == $past(irq_pc)));
endmodule

bind sreg_ctx sctx_chk u_chk (
  .clk(clk), .rst_n(rst_i_n),
  .exc_irq(exc_irq), .exc_fiq(exc_fiq), .exc_swi(exc_swi),
  .ret_en(ret_en), .ret_cls(ret_cls),
  .sr(sr), .pc(pc),
  .irq_pc(set_pc[0]), .irq_ssr(set_sr[0]),
  .fiq_pc(set_pc[1]), .fiq_ssr(set_sr[1]),
  .swi_ssr(swi_ssr_q)
);

// File: tb/sim_sreg_ctx.sv
`timescale 1ns/1ps
module sim_sreg_ctx;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  wr_sel, rd_sel;
  logic [15:0] wr_data, rd_data;
  logic        pc_ld;
  logic [21:0] pc_in;
  logic        v_we, v_val, t_we, t_val;
  logic [1:0]  z_we, z_val;
  logic        exc_irq, exc_fiq, exc_swi, ret_en;
  logic [1:0]  ret_cls;
  logic [21:0] swi_ret_addr;
  logic        gpr_we;
  logic [5:0]  gpr_ext;
  logic [15:0] gpr_base, sr;
  logic [21:0] pc;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  sreg_ctx u0 (.*);

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; wr_sel = 0; wr_data = 0; pc_ld = 0; pc_in = 0;
    v_we = 0; v_val = 0; t_we = 0; t_val = 0; z_we = 0; z_val = 0;
    exc_irq = 0; exc_fiq = 0; exc_swi = 0; ret_en = 0; ret_cls = 0;
  endtask

  task automatic wreg(input logic [3:0] s, input logic [15:0] d);
    wr_en = 1; wr_sel = s; wr_data = d; tick(); idle();
  endtask

  task automatic rreg(input string req, input logic [3:0] s, input logic [15:0] exp);
    rd_sel = s; #1; chk(req, 32'(rd_data), 32'(exp));
  endtask

  task automatic t_reset();
    chk("R1 sr", 32'(sr), 32'h0040);
    chk("R1 pc", 32'(pc), 32'h0);
    rreg("R1 irq ssr", 4'd5, 16'h0);
    rreg("R11 unused select", 4'd12, 16'h0);
  endtask

  task automatic t_priv_write();
    wreg(4'd0, 16'hFFFF);
    chk("R3 R2 priv write", 32'(sr), 32'h807F);
    wreg(4'd1, 16'hABCD);
    wreg(4'd2, 16'hFFFF);
    chk("R2 R12 pc", 32'(pc), 32'h3FABCC);
    rreg("R11 pc high", 4'd2, 16'h003F);
    wreg(4'd5, 16'hFFFF);
    rreg("R2 ssr reserved", 4'd5, 16'h807F);
    wreg(4'd3, 16'hFFFF);
    rreg("R2 save low bit0", 4'd3, 16'hFFFE);
  endtask

  task automatic t_user_write();
    wreg(4'd0, 16'h0007);
    chk("R3 leave priv", 32'(sr), 32'h0007);
    wreg(4'd0, 16'hFFFF);
    chk("R4 user set", 32'(sr), 32'h803F);
    wreg(4'd0, 16'h0000);
    chk("R4 user clear", 32'(sr), 32'h0007);
  endtask

  task automatic t_flags();
    v_we = 1; v_val = 1; t_we = 1; t_val = 1; z_we = 2'b11; z_val = 2'b01;
    tick(); idle();
    chk("R5 flags user mode", 32'(sr), 32'h801F);
    wr_en = 1; wr_sel = 0; wr_data = 16'h0000; v_we = 1; v_val = 1;
    tick(); idle();
    chk("R5 strobe over write", 32'(sr), 32'h000F);
  endtask

  task automatic t_irq();
    exc_irq = 1; v_we = 1; v_val = 0; wr_en = 1; wr_sel = 0; wr_data = 16'h8000;
    tick(); idle();
    chk("R6 R9 sr after irq", 32'(sr), 32'h004D);
    rreg("R6 irq ssr", 4'd5, 16'h000F);
    rreg("R6 irq pch", 4'd4, 16'h003F);
    rreg("R6 irq pcl", 4'd3, 16'hABCC);
  endtask

  task automatic t_fiq();
    pc_ld = 1; pc_in = 22'h012345; tick(); idle();
    chk("R2 pc load bit0", 32'(pc), 32'h012344);
    exc_fiq = 1; tick(); idle();
    chk("R7 sr after fiq", 32'(sr), 32'h004C);
    rreg("R7 fiq ssr", 4'd8, 16'h004D);
    rreg("R7 fiq pch", 4'd7, 16'h0001);
    rreg("R7 fiq pcl", 4'd6, 16'h2344);
    rreg("R7 irq set kept", 4'd5, 16'h000F);
  endtask

  task automatic t_swi();
    pc_ld = 1; pc_in = 22'h2A5A5A; tick(); idle();
    wreg(4'd0, 16'h0003);
    chk("R3 user entry prep", 32'(sr), 32'h0003);
    exc_swi = 1; #1;
    chk("R8 gpr we", 32'(gpr_we), 32'h1);
    chk("R8 gpr ext", 32'(gpr_ext), 32'h2A);
    chk("R8 gpr base", 32'(gpr_base), 32'h5A5A);
    @(posedge clk); #1; idle();
    chk("R8 sr after swi", 32'(sr), 32'h0043);
    rreg("R8 swi ssr", 4'd9, 16'h0003);
  endtask

  task automatic t_ret();
    ret_en = 1; ret_cls = 2'd0; tick(); idle();
    chk("R10 irq ret sr", 32'(sr), 32'h000F);
    chk("R10 irq ret pc", 32'(pc), 32'h3FABCC);
    ret_en = 1; ret_cls = 2'd2; swi_ret_addr = 22'h155555; tick(); idle();
    chk("R10 swi ret sr", 32'(sr), 32'h0003);
    chk("R10 swi ret pc", 32'(pc), 32'h155554);
    ret_en = 1; ret_cls = 2'd1; tick(); idle();
    chk("R10 fiq ret sr", 32'(sr), 32'h004D);
    chk("R10 fiq ret pc", 32'(pc), 32'h012344);
    exc_irq = 1; ret_en = 1; ret_cls = 2'd2; tick(); idle();
    chk("R9 entry over ret sr", 32'(sr), 32'h004D);
    chk("R9 entry over ret pc", 32'(pc), 32'h012344);
    rreg("R9 irq ssr recapture", 4'd5, 16'h004D);
  endtask

  initial begin
    idle(); rd_sel = 0; swi_ret_addr = 0; rst_n = 0;
    repeat (3) tick();
    rst_n = 1;
    repeat (3) tick();
    t_reset();
    t_priv_write();
    t_user_write();
    t_flags();
    t_irq();
    t_fiq();
    t_swi();
    t_ret();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule